// File: doc/BRIEF.md
# GPIO Edge Interrupt Cause Unit

This block watches a bank of up to 32 general-purpose input pins and turns selected transitions into interrupt requests. Each pin passes through a multi-stage synchronizer. Two enable registers pick the transitions that count for each pin: one for low-to-high and one for high-to-low. Setting both catches either direction. A counted transition sets a sticky cause bit for that pin. The bit stays set until software clears it.

A mask register chooses which cause bits can reach the single interrupt output. Software reads the pending vector, which is the cause bits already ANDed with the mask, at its own offset. It acknowledges events by writing ones to a clear register. The interrupt output is a registered OR of all pending bits, so the line can be shared with other sources. A cause bit that latches while its mask bit is 0 stays hidden. It shows up as soon as the mask bit is set.

Register map, word-aligned on an 8-bit address with a 32-bit data bus:
- 0x00: rising-edge enable (read/write).
- 0x04: falling-edge enable (read/write).
- 0x08: event mask (read/write).
- 0x0C: pending vector (read-only).
- 0x10: clear (write-one-to-clear, reads 0).

Bit n of every register belongs to pin n.

Top module: `gpio_edge_cause`

## Requirements
- R1: After reset the rising-edge enable, falling-edge enable, event mask and cause state are all zero. Every register reads 0 and `irq_o` is 0.
- R2: When bit n of the rising-edge enable (0x00) is 1, a 0-to-1 change on `pin_i[n]` sets cause bit n. The bit reads back in the pending vector (0x0C) when mask bit n is 1.
- R3: When bit n of the falling-edge enable (0x04) is 1, a 1-to-0 change on `pin_i[n]` sets cause bit n.
- R4: With both enable bits set for a pin, either transition sets its cause bit.
- R5: A transition whose direction is not enabled for that pin sets no cause bit.
- R6: A cause bit stays set after the pin returns to its earlier level, and stays set until it is cleared.
- R7: Writing a word to the clear register (0x10) clears exactly the cause bits written as 1. Cause bits written as 0 keep their value.
- R8: When a qualifying edge and a clear of the same pin occur in the same clock cycle, the cause bit ends up set.
- R9: A cause bit latches even while its mask bit (0x08) is 0. In that state it is absent from the pending vector and does not drive `irq_o`. Setting the mask bit later exposes the bit and raises `irq_o`.
- R10: `irq_o` is 1 exactly one clock after the pending vector is non-zero, and 0 one clock after the pending vector becomes zero.
- R11: A read returns its data on `bus_rdata` one clock after the read cycle, and `bus_rdata` holds its value when the bus is idle. The enable and mask registers read back their last written value. The clear register and unmapped offsets read 0. Writes to the pending vector offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Asynchronous pin levels |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Shared interrupt, OR of all pending bits |

## Verification
A wrong cause bit shows up on `bus_rdata` at the first read of the pending vector after the edge. The edge reaches the cause bit two clocks after the pin is sampled, and the read data arrives one clock after the read. The same fault reaches `irq_o` one clock after the cause bit, provided the mask bit is set.

A cause bit that latched but was masked stays hidden from both outputs until the mask is written. For this reason the bench unmasks such bits on purpose and checks that the line rises. A clear/set race that resolves the wrong way leaves the pending vector at 0 where it should read 1, and the very next read shows it.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int BUS_W = 32;

  // Register offsets (byte addresses, 8-bit decode)
  localparam logic [7:0] OFS_RISE = 8'h00;
  localparam logic [7:0] OFS_FALL = 8'h04;
  localparam logic [7:0] OFS_MASK = 8'h08;
  localparam logic [7:0] OFS_PEND = 8'h0C;
  localparam logic [7:0] OFS_CLR  = 8'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RISE,
    SEL_FALL,
    SEL_MASK,
    SEL_PEND,
    SEL_CLR
  } reg_sel_e;

  function automatic reg_sel_e f_decode(input logic [7:0] a);
    case (a)
      OFS_RISE: return SEL_RISE;
      OFS_FALL: return SEL_FALL;
      OFS_MASK: return SEL_MASK;
      OFS_PEND: return SEL_PEND;
      OFS_CLR:  return SEL_CLR;
      default:  return SEL_NONE;
    endcase
  endfunction

  // One pin: does the transition prev->cur qualify under the enables?
  function automatic logic f_edge_hit(input logic prev, input logic cur,
                                      input logic ren, input logic fen);
    return (ren & cur & ~prev) | (fen & prev & ~cur);
  endfunction

  // One pin: next cause value; a set beats a clear in the same cycle.
  function automatic logic f_cause_next(input logic cur, input logic set,
                                        input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_cause_bank.sv
module gpio_cause_bank
  import gpio_edge_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] lvl_i,
  input  logic [NPINS-1:0] rise_en_i,
  input  logic [NPINS-1:0] fall_en_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] set_o,
  output logic [NPINS-1:0] cause_o
);

  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] cause_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    assign set_o[n] = f_edge_hit(prev_q[n], lvl_i[n], rise_en_i[n], fall_en_i[n]);
    always_ff @(posedge clk) begin
      if (rst) cause_q[n] <= 1'b0;
      else     cause_q[n] <= f_cause_next(cause_q[n], set_o[n], clr_i[n]);
    end
  end

  assign cause_o = cause_q;

  // A detected edge is always captured, even against a clear (R8)
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (set_o != '0) |=> ((cause_q & $past(set_o)) == $past(set_o)));

  // Set bits survive unless cleared (R6)
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cause_q & $past(cause_q & ~clr_i)) == $past(cause_q & ~clr_i)));

  // No cause bit appears without a qualifying edge (R5)
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(set_o)) == '0));

endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_edge_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pend_i,
  output logic [NPINS-1:0]  rise_en_o,
  output logic [NPINS-1:0]  fall_en_o,
  output logic [NPINS-1:0]  mask_o,
  output logic [NPINS-1:0]  clr_o
);

  reg_sel_e         sel;
  logic             wr_stb;
  logic             rd_stb;
  logic [BUS_W-1:0] rd_mux;
  logic [NPINS-1:0] wr_bits;

  assign sel     = f_decode(8'(bus_addr));
  assign wr_stb  = bus_en & bus_wr;
  assign rd_stb  = bus_en & ~bus_wr;
  assign wr_bits = bus_wdata[NPINS-1:0];
  assign clr_o   = (wr_stb && sel == SEL_CLR) ? wr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_en_o <= '0;
      fall_en_o <= '0;
      mask_o    <= '0;
    end else if (wr_stb) begin
      case (sel)
        SEL_RISE: rise_en_o <= wr_bits;
        SEL_FALL: fall_en_o <= wr_bits;
        SEL_MASK: mask_o    <= wr_bits;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_RISE: rd_mux[NPINS-1:0] = rise_en_o;
      SEL_FALL: rd_mux[NPINS-1:0] = fall_en_o;
      SEL_MASK: rd_mux[NPINS-1:0] = mask_o;
      SEL_PEND: rd_mux[NPINS-1:0] = pend_i;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_stb) bus_rdata <= rd_mux;
  end

  // Read data only moves on a read (R11)
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(bus_rdata));

  // Enables only move on a write (R11)
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> ($stable(rise_en_o) && $stable(fall_en_o) && $stable(mask_o)));

endmodule

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause
  import gpio_edge_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o
);

  logic [NPINS-1:0] lvl_sync;
  logic [NPINS-1:0] rise_en;
  logic [NPINS-1:0] fall_en;
  logic [NPINS-1:0] mask;
  logic [NPINS-1:0] clr_vec;
  logic [NPINS-1:0] set_vec;
  logic [NPINS-1:0] cause;
  logic [NPINS-1:0] pending;

  gpio_pin_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_i),
    .q_o (lvl_sync)
  );

  gpio_cause_bank #(.NPINS(NPINS)) u_cause (
    .clk       (clk),
    .rst       (rst),
    .lvl_i     (lvl_sync),
    .rise_en_i (rise_en),
    .fall_en_i (fall_en),
    .clr_i     (clr_vec),
    .set_o     (set_vec),
    .cause_o   (cause)
  );

  gpio_reg_bank #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pend_i    (pending),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en),
    .mask_o    (mask),
    .clr_o     (clr_vec)
  );

  assign pending = cause & mask;

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |pending;
  end

  // Interrupt rises one clock after anything is pending (R10)
  p_irq_high_r10: assert property (@(posedge clk) disable iff (rst)
    (pending != '0) |=> irq_o);

  // Interrupt drops one clock after nothing is pending (R10)
  p_irq_low_r10: assert property (@(posedge clk) disable iff (rst)
    (pending == '0) |=> !irq_o);

  // A masked cause never drives the line by itself (R9)
  p_mask_gate_r9: assert property (@(posedge clk) disable iff (rst)
    ((cause & mask) == '0) |=> !irq_o);

endmodule

// File: tb/sim_gpio_edge_cause.sv
module sim_gpio_edge_cause;

  localparam int NP = 32;
  localparam logic [7:0] A_RISE = 8'h00, A_FALL = 8'h04, A_MASK = 8'h08,
                         A_PEND = 8'h0C, A_CLR = 8'h10, A_GAP = 8'h20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pins = '0;
  logic          bus_en = 1'b0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_edge_cause u0 (
    .clk(clk), .rst(rst), .pin_i(pins), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  // Pin sampled at the next edge; cause two edges later, irq one more.
  task automatic drive(input logic [NP-1:0] v);
    @(negedge clk);
    pins = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rd(A_RISE, d); check("R1 rise", d, 0);
    rd(A_FALL, d); check("R1 fall", d, 0);
    rd(A_MASK, d); check("R1 mask", d, 0);
    rd(A_PEND, d); check("R1 pend", d, 0);
    check("R1 irq", {31'd0, irq}, 0);

    // R11: readback, unmapped, clear reads 0, pending not writable
    wr(A_RISE, 32'h1234_5678); rd(A_RISE, d); check("R11 rise rb", d, 32'h1234_5678);
    wr(A_FALL, 32'hCAFE_F00D); rd(A_FALL, d); check("R11 fall rb", d, 32'hCAFE_F00D);
    wr(A_MASK, 32'h0F0F_00FF); rd(A_MASK, d); check("R11 mask rb", d, 32'h0F0F_00FF);
    rd(A_GAP, d);  check("R11 unmapped", d, 0);
    rd(A_CLR, d);  check("R11 clr reads 0", d, 0);
    wr(A_PEND, 32'hFFFF_FFFF); rd(A_PEND, d); check("R11 pend write ignored", d, 0);
    @(negedge clk); check("R11 rdata holds", bus_rdata, 0);
    check("R11 irq after pend write", {31'd0, irq}, 0);

    // Sweep every pin under every enable combination (R2 R3 R4 R5 R6)
    wr(A_MASK, 32'hFFFF_FFFF);
    for (int p = 0; p < NP; p++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        logic ren, fen;
        logic [31:0] bit_p;
        string tag;
        ren = cfg[0]; fen = cfg[1];
        bit_p = 32'd1 << p;
        tag = (cfg == 0) ? "R5" : (cfg == 1) ? "R2" : (cfg == 2) ? "R3" : "R4";
        wr(A_RISE, ren ? bit_p : 32'd0);
        wr(A_FALL, fen ? bit_p : 32'd0);
        wr(A_CLR, 32'hFFFF_FFFF);
        drive(NP'(bit_p));
        rd(A_PEND, d); check({tag, " rise edge"}, d, ren ? bit_p : 32'd0);
        check({tag, " irq after rise"}, {31'd0, irq}, {31'd0, ren});
        drive('0);
        rd(A_PEND, d);
        check({(cfg == 1) ? "R6" : tag, " after fall"}, d, (ren | fen) ? bit_p : 32'd0);
        wr(A_CLR, bit_p); settle();
        rd(A_PEND, d); check("R7 cleared", d, 0);
        check("R10 irq low", {31'd0, irq}, 0);
      end
    end

    // Multi-pin pattern; R7 partial clear
    wr(A_RISE, 32'hFFFF_FFFF); wr(A_FALL, 0); wr(A_CLR, 32'hFFFF_FFFF);
    drive(32'hA5A5_0F0F);
    rd(A_PEND, d); check("R2 pattern", d, 32'hA5A5_0F0F);
    drive(32'h0000_0000);
    rd(A_PEND, d); check("R6 pattern sticky", d, 32'hA5A5_0F0F);
    wr(A_CLR, 32'h0505_0303); settle();
    rd(A_PEND, d); check("R7 partial clear", d, 32'hA0A0_0C0C);
    check("R10 irq still high", {31'd0, irq}, 1);
    wr(A_CLR, 32'hFFFF_FFFF); settle();
    check("R10 irq drops", {31'd0, irq}, 0);

    // R9: masked latch then unmask
    wr(A_MASK, 0); wr(A_RISE, 32'h20);
    drive(32'h20);
    rd(A_PEND, d); check("R9 masked pend", d, 0);
    check("R9 masked irq", {31'd0, irq}, 0);
    drive(0);
    wr(A_MASK, 32'h20);
    rd(A_PEND, d); check("R9 exposed", d, 32'h20);
    check("R9 irq raised", {31'd0, irq}, 1);
    wr(A_CLR, 32'hFFFF_FFFF); settle();

    // R8: clear and edge in the same cycle
    wr(A_RISE, 32'h1); wr(A_MASK, 32'h1); wr(A_CLR, 32'hFFFF_FFFF);
    @(negedge clk); pins = 32'h1;          // sampled at edge k
    @(negedge clk);                        // after k
    @(negedge clk);                        // after k+1
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h1; // edge k+2
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
    rd(A_PEND, d); check("R8 set wins", d, 32'h1);
    wr(A_CLR, 32'h1);
    rd(A_PEND, d); check("R7 clear after race", d, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule